// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Settling Suppression

This block turns a 1-bit delta-sigma modulator stream into signed parallel words at a reduced rate. Each modulator sample is qualified by a clock enable and maps to +1 for a one and -1 for a zero. Three wrap-around integrators run at the modulator rate. Three differencing stages run once per decimation block. The result is scaled by a shift, so a full-scale stream gives the same word at every ratio.

A 3-bit rate code selects a power-of-two decimation ratio while the block runs. Conversion runs while the start input is high. Dropping start, or changing the rate code, clears every accumulator and the block counters. When conversion resumes, the first two decimated words are discarded because the cubic impulse response is still partly filled with the zeros left by the clear. The first word marked valid is the third one, produced once the window holds only real samples. From then on one word follows every block of accepted samples. Because the response is the cube of a box of one block length, it has nulls at the output rate and at its integer multiples.

Top module: `sinc3_decim`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and `data_o` is zero until the first settled word.
- R2: A modulator one counts as +1 and a zero as -1. A stream of all ones gives the word +2^(OUT_W-2), which is 16384 by default. A stream of all zeros gives -2^(OUT_W-2).
- R3: Rate code c selects a decimation ratio R = 2^(LOG2_BASE+c). With the defaults this runs from R = 4 for code 0 to R = 512 for code 7.
- R4: Each valid word equals S * 2^(OUT_W-2) / R^3, floored. S is the triple moving sum, with window length R in each stage, of the ±1 samples ending at the last accepted sample of the block.
- R5: `valid_o` is a one-cycle pulse, issued once per R accepted samples once the filter has settled. `data_o` holds its value between pulses.
- R6: After a restart, the first valid pulse comes one clock after the 3R-th accepted sample. The two earlier block results are not presented.
- R7: In a cycle with `start_i` low, the filter state is cleared and that cycle's sample is discarded. No valid pulse follows a cycle with start low.
- R8: A cycle whose rate code differs from the previous cycle's code clears the state in the same way. It discards its sample and restarts the settling count.
- R9: Cycles with `mod_ce_i` low have no effect on the result. `mod_bit_i` is ignored in them, and all timing is counted in accepted samples.
- R10: A periodic stream whose period divides R, such as alternating ones and zeros, gives an exact settled output equal to its mean. For alternating ones and zeros that value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion runs while high |
| rate_i | input | RATE_W | Decimation ratio code |
| mod_ce_i | input | 1 | Modulator sample qualifier |
| mod_bit_i | input | 1 | Modulator bitstream sample |
| data_o | output | OUT_W | Scaled signed output word |
| valid_o | output | 1 | One-cycle pulse marking a new settled word |

## Verification
A word becomes due exactly one clock after the cycle that carries the 3R-th accepted sample after a restart, and again one clock after every further R-th sample. A cycle that clears the filter, whether from start low or a rate change, must produce no pulse in the following clock. The bench drives one cycle at each falling edge and computes from its own running triple sums whether a pulse and which word are due after the next rising edge. It compares `valid_o` and `data_o` at the following falling edge, so every cycle is checked against its own expectation, including the cycles where `data_o` must hold.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    // Filter order is fixed at three; kept as a constant so stage arrays size from it.
    localparam int unsigned SINC_ORDER = 3;

    // Largest log2 ratio reachable from a code field of the given width.
    function automatic int unsigned max_log2_ratio(input int unsigned rate_w,
                                                   input int unsigned log2_base);
        return log2_base + (1 << rate_w) - 1;
    endfunction

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
    import sinc3_pkg::*;
#(
    parameter int unsigned RATE_W    = 3,
    parameter int unsigned LOG2_BASE = 2,
    parameter int unsigned LOG2_MAX  = max_log2_ratio(RATE_W, LOG2_BASE),
    parameter int unsigned L2_W      = $clog2(LOG2_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              ce_i,
    output logic              clr_o,
    output logic              dump_o,
    output logic              emit_o,
    output logic [L2_W-1:0]   log2r_o
);
    localparam int unsigned CNT_W     = LOG2_MAX;
    localparam logic [1:0]  SETTLED   = 2'd2;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        settle;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] lim;
    logic             last;

    always_comb begin
        log2r_o = L2_W'(LOG2_BASE) + L2_W'(rate_i);
        one_sh  = {{CNT_W{1'b0}}, 1'b1} << log2r_o;
        lim     = one_sh[CNT_W-1:0] - CNT_W'(1);
        last    = (st_q.cnt == lim);
        clr_o   = !start_i || (rate_i != st_q.rate);
        dump_o  = !clr_o && ce_i && last;
        emit_o  = dump_o && (st_q.settle == SETTLED);

        st_d      = st_q;
        st_d.rate = rate_i;
        if (clr_o) begin
            st_d.cnt    = '0;
            st_d.settle = '0;
        end else if (ce_i) begin
            st_d.cnt = last ? '0 : st_q.cnt + CNT_W'(1);
            if (dump_o && st_q.settle != SETTLED) begin
                st_d.settle = st_q.settle + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sinc3_pkg::*;
#(
    parameter int unsigned ACC_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ce_i,
    input  logic             bit_i,
    output logic [ACC_W-1:0] sum_o
);
    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t [SINC_ORDER-1:0] stage;
    } integ_t;

    integ_t st_d, st_q;
    acc_t [SINC_ORDER-1:0] nxt;
    acc_t                  x;

    always_comb begin
        x = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};
        for (int k = 0; k < SINC_ORDER; k++) begin
            nxt[k] = st_q.stage[k] + ((k == 0) ? x : nxt[(k == 0) ? 0 : k - 1]);
        end
        sum_o = nxt[SINC_ORDER-1];

        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (ce_i) begin
            st_d.stage = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int unsigned ACC_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [ACC_W-1:0] din_i,
    output logic [ACC_W-1:0] dout_o
);
    typedef logic [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t [SINC_ORDER-1:0] dly;
    } comb_t;

    comb_t st_d, st_q;
    acc_t [SINC_ORDER-1:0] diff;
    acc_t [SINC_ORDER-1:0] feed;

    for (genvar k = 0; k < SINC_ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign feed[k] = din_i;
        end else begin : g_rest
            assign feed[k] = diff[k-1];
        end
        assign diff[k] = feed[k] - st_q.dly[k];
    end

    always_comb begin
        dout_o = diff[SINC_ORDER-1];
        st_d   = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (en_i) begin
            st_d.dly = feed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int unsigned RATE_W    = 3,
    parameter int unsigned LOG2_BASE = 2,
    parameter int unsigned OUT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              mod_ce_i,
    input  logic              mod_bit_i,
    output logic [OUT_W-1:0]  data_o,
    output logic              valid_o
);
    localparam int unsigned LOG2_MAX = max_log2_ratio(RATE_W, LOG2_BASE);
    localparam int unsigned ACC_W    = SINC_ORDER * LOG2_MAX + 2;
    localparam int unsigned L2_W     = $clog2(LOG2_MAX + 1);

    typedef struct packed {
        logic [OUT_W-1:0] data;
        logic             valid;
    } out_t;

    out_t st_d, st_q;

    logic             clr, dump, emit;
    logic [L2_W-1:0]  log2r;
    logic [ACC_W-1:0] integ_sum, comb_out, scaled;
    int unsigned      shift_amt;

    sinc3_ctrl #(
        .RATE_W   (RATE_W),
        .LOG2_BASE(LOG2_BASE),
        .LOG2_MAX (LOG2_MAX),
        .L2_W     (L2_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .rate_i (rate_i),
        .ce_i   (mod_ce_i),
        .clr_o  (clr),
        .dump_o (dump),
        .emit_o (emit),
        .log2r_o(log2r)
    );

    sinc3_integ #(.ACC_W(ACC_W)) u_integ (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clr),
        .ce_i (mod_ce_i),
        .bit_i(mod_bit_i),
        .sum_o(integ_sum)
    );

    sinc3_comb #(.ACC_W(ACC_W)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (dump),
        .din_i (integ_sum),
        .dout_o(comb_out)
    );

    always_comb begin
        // Normalise every ratio to the same full scale, then keep the top bits.
        shift_amt = SINC_ORDER * (LOG2_MAX - 32'(log2r));
        scaled    = comb_out << shift_amt;

        st_d       = st_q;
        st_d.valid = emit;
        if (emit) begin
            st_d.data = scaled[ACC_W-1 -: OUT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
    parameter int unsigned RATE_W    = 3,
    parameter int unsigned LOG2_BASE = 2,
    parameter int unsigned OUT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [RATE_W-1:0] rate_i,
    input logic              mod_ce_i,
    input logic              mod_bit_i,
    input logic [OUT_W-1:0]  data_o,
    input logic              valid_o
);
    localparam logic signed [OUT_W-1:0] FS_POS = OUT_W'(1 << (OUT_W - 2));
    localparam logic signed [OUT_W-1:0] FS_NEG = -FS_POS;

    logic [RATE_W-1:0] rate_prev;
    logic [31:0]       seen;
    logic [31:0]       blk;
    logic              restart;

    assign restart = !start_i || (rate_i != rate_prev);
    assign blk     = 32'd1 << (LOG2_BASE + 32'(rate_prev));

    // Independent count of accepted samples since the last restart.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_prev <= '0;
            seen      <= '0;
        end else begin
            rate_prev <= rate_i;
            seen      <= restart ? 32'd0 : seen + 32'(mod_ce_i);
        end
    end

    AST_SETTLED_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (seen >= 32'd3 * blk)); // R6

    AST_VALID_ON_BLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((seen & (blk - 32'd1)) == 32'd0)); // R5

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R5

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o)); // R5

    AST_STOP_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o); // R7

    AST_RATE_SWITCH_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rate_i != rate_prev) |=> !valid_o); // R8

    AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(mod_ce_i)); // R9

    AST_FULL_SCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($signed(data_o) <= FS_POS && $signed(data_o) >= FS_NEG)); // R2

endmodule

bind sinc3_decim sinc3_decim_chk #(
    .RATE_W   (RATE_W),
    .LOG2_BASE(LOG2_BASE),
    .OUT_W    (OUT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rate_i   (rate_i),
    .mod_ce_i (mod_ce_i),
    .mod_bit_i(mod_bit_i),
    .data_o   (data_o),
    .valid_o  (valid_o)
);

// File: tb/sinc3_decim_tb.sv
module sinc3_decim_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RATE_W     = 3;
    localparam int LOG2_BASE  = 2;
    localparam int OUT_W      = 16;
    localparam int LOG2_MAX   = LOG2_BASE + (1 << RATE_W) - 1;
    localparam int ACC_W      = 3 * LOG2_MAX + 2;
    localparam int NMAX       = 4096;
    localparam int WATCHDOG   = 150000;

    localparam int PAT_ONE  = 0;
    localparam int PAT_ZERO = 1;
    localparam int PAT_ALT  = 2;
    localparam int PAT_STEP = 3;
    localparam int PAT_DENS = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic [RATE_W-1:0] rate_i;
    logic              mod_ce_i;
    logic              mod_bit_i;
    logic [OUT_W-1:0]  data_o;
    logic              valid_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sinc3_decim #(
        .RATE_W   (RATE_W),
        .LOG2_BASE(LOG2_BASE),
        .OUT_W    (OUT_W)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .rate_i   (rate_i),
        .mod_ce_i (mod_ce_i),
        .mod_bit_i(mod_bit_i),
        .data_o   (data_o),
        .valid_o  (valid_o)
    );

    // Reference model state: triple running box sums over accepted samples.
    longint x_h  [NMAX];
    longint s1_h [NMAX];
    longint s2_h [NMAX];
    longint s3;
    int     n;
    int     prev_code;
    bit     exp_valid;
    longint exp_data;
    longint last_data;
    int     density;
    string  vtag;
    string  dtag;
    int     checks;
    int     fails;
    bit     done;

    function automatic int ratio(input int code);
        return 1 << (LOG2_BASE + code);
    endfunction

    function automatic longint scale_word(input longint s, input int code);
        longint v;
        v = s <<< (3 * (LOG2_MAX - (LOG2_BASE + code)));
        return v >>> (ACC_W - OUT_W);
    endfunction

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_outputs();
        longint got;
        got = longint'($signed(data_o));
        check(valid_o == exp_valid, vtag, longint'(valid_o), longint'(exp_valid));
        if (exp_valid) begin
            check(got == exp_data, dtag, got, exp_data);
            last_data = exp_data;
        end else begin
            check(got == last_data, "R5", got, last_data);
        end
    endtask

    task automatic push(input bit b, input int code);
        int     r;
        longint xv;
        r  = ratio(code);
        xv = b ? 64'sd1 : -64'sd1;
        x_h[n]  = xv;
        s1_h[n] = ((n > 0) ? s1_h[n-1] : 0) + xv - ((n >= r) ? x_h[n-r] : 0);
        s2_h[n] = ((n > 0) ? s2_h[n-1] : 0) + s1_h[n] - ((n >= r) ? s1_h[n-r] : 0);
        s3      = s3 + s2_h[n] - ((n >= r) ? s2_h[n-r] : 0);
        n++;
        if ((n % r) == 0 && (n / r) >= 3) begin
            exp_valid = 1'b1;
            exp_data  = scale_word(s3, code);
        end
    endtask

    task automatic step(input bit st, input int code, input int ce_pct, input int pat);
        bit ce;
        bit b;
        @(negedge clk);
        check_outputs();
        ce = ($urandom % 100) < ce_pct;
        case (pat)
            PAT_ONE:  b = 1'b1;
            PAT_ZERO: b = 1'b0;
            PAT_ALT:  b = n[0];
            PAT_STEP: b = (n >= 4 * ratio(code));
            default:  b = ($urandom % 100) < density;
        endcase
        if (!ce) b = $urandom % 2;
        start_i   = st;
        rate_i    = code[RATE_W-1:0];
        mod_ce_i  = ce;
        mod_bit_i = b;
        exp_valid = 1'b0;
        if (!st || code != prev_code) begin
            n  = 0;
            s3 = 0;
        end else if (ce) begin
            push(b, code);
        end
        prev_code = code;
    endtask

    task automatic segment(input int code, input int nout, input int pat, input int ce_pct,
                           input string vt, input string dt);
        vtag = vt;
        dtag = dt;
        do begin
            step(1'b1, code, ce_pct, pat);
        end while (n < nout * ratio(code));
    endtask

    task automatic stop_run(input int cycles);
        vtag = "R7";
        dtag = "R7";
        for (int i = 0; i < cycles; i++) begin
            step(1'b0, prev_code, 70, PAT_DENS);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        checks = 0; fails = 0; done = 1'b0;
        n = 0; s3 = 0; prev_code = 0; exp_valid = 1'b0; exp_data = 0; last_data = 0;
        density = 50; vtag = "R1"; dtag = "R1";
        rst_n = 1'b0; start_i = 1'b0; rate_i = '0; mod_ce_i = 1'b0; mod_bit_i = 1'b0;
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0, "R1", longint'(valid_o), 0);
        check(data_o == '0, "R1", longint'($signed(data_o)), 0);
        rst_n = 1'b1;

        // Full scale both ways; first pulse timing after start.
        segment(0, 8, PAT_ONE, 100, "R6", "R2");
        segment(1, 6, PAT_ZERO, 70, "R8", "R2");
        // Rate switch while running; periodic input sits in a null.
        segment(2, 6, PAT_ALT, 100, "R8", "R10");
        segment(3, 6, PAT_STEP, 80, "R5", "R4");

        // Random density streams at random ratios, each a different code.
        for (int i = 0; i < 6; i++) begin
            int c;
            c = (prev_code + 1 + int'($urandom % 4)) % 5;
            density = int'($urandom % 101);
            segment(c, 6, PAT_DENS, 50 + int'($urandom % 51), "R5", "R4");
        end

        stop_run(20);

        // Sparse sample qualifier.
        density = 30;
        segment(1, 8, PAT_DENS, 25, "R9", "R9");

        // Stop in mid-settle, then resume at the same ratio.
        density = 65;
        segment(2, 2, PAT_DENS, 90, "R6", "R4");
        stop_run(3);
        segment(2, 5, PAT_DENS, 90, "R7", "R4");

        // Largest and a middle ratio.
        segment(7, 5, PAT_ONE, 95, "R3", "R3");
        density = 80;
        segment(5, 4, PAT_DENS, 85, "R3", "R4");

        stop_run(2);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d expected %0d cycles", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule